// File: doc/BRIEF.md
# Interrupt Accumulator Scan Dispatcher

This block services a summary interrupt for up to 256 peripheral ports. Each port keeps an 8-bit pending status. The OR of each status forms one bit of a 32-bit accumulated word, so there is one word for every 32 ports. When `svc_start` is pulsed, the block walks the accumulated words that cover the mapped port range. It finds each pending port and checks that port's enable. If the port is enabled, the block reads the status and clears it. It then emits one event per set status bit. Each event carries the port index, the port's slave id and peripheral id, and the status bit number. A show-only pass emits the same events but leaves the status untouched.

Port identifiers, enables and owner fields live in internal register arrays, which are loaded through a small configuration write port. Mapping a port widens the scanned range. A one-shot initialisation pulse snapshots the pending bits of ports 0..31 as a stuck mask. Ports owned by this host are taken out of that mask. Later passes ignore the ports that remain in the mask.

The controller is a five-state machine:
- `ST_IDLE` waits for a start or init pulse.
- `ST_LOAD` latches the masked accumulated word for the current word index.
- `ST_FIND` picks the lowest pending port in that word. When the word is empty it moves to the next word, or ends the pass after the last word.
- `ST_CHECK` tests the port's enable. A disabled port returns to `ST_FIND`. An enabled port has its status captured and cleared, then goes to `ST_EMIT`.
- `ST_EMIT` presents events through a valid/ready handshake. It returns to `ST_FIND` once every captured bit has been handed off.

Top module: `irqd_scan_dispatch`

## Requirements
- R1: After reset, `busy`, `svc_done` and `evt_valid` are 0. With no port mapped, a pass emits no event and pulses `svc_done` once.
- R2: A configuration write with `cfg_kind`=0 maps port `cfg_port` to slave id `cfg_data[11:8]` and peripheral id `cfg_data[7:0]`, and marks it valid. A map write to an already valid port is ignored. `cfg_kind`=1 writes enable `cfg_data[0]`. `cfg_kind`=2 writes owner `cfg_data[2:0]`. `cfg_kind`=3 has no effect.
- R3: The lowest mapped port starts at 255 and the highest at 0. Every accepted map lowers the lowest if smaller. The highest is raised only for ports below `INTR_LIMIT` (200 by default). A pass scans only words from lowest>>5 to highest>>5, so pending ports outside them produce no event.
- R4: Words are visited in ascending order, and bits within a word from 0 to 31. The reported port index equals word*32+bit.
- R5: A pending port whose enable is 0 produces no event, and its status is left pending. It is dispatched by a later pass after it is enabled.
- R6: In a normal pass, an enabled port's status is cleared when it is captured, so an immediately following pass emits nothing for it.
- R7: When `svc_show` is 1 at start, events are emitted exactly as in a normal pass but no status is cleared. A second pass repeats the same events.
- R8: For each serviced port, events cover the set status bits in ascending bit order. Each event carries the port's stored slave and peripheral ids and the bit number on `evt_bit`.
- R9: An `init_stuck` pulse in idle captures the pending bits of ports 0..31 as a stuck mask, except ports whose owner equals `host_env`. Masked ports produce no events in later passes, while unmasked ports of word 0 do.
- R10: While `evt_valid` is 1 and `evt_ready` is 0, the event fields hold steady. Each valid/ready handshake consumes exactly one event. `svc_done` pulses for one cycle while `busy` is 0, once at the end of each pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_env | input | 3 | Owner id of this host |
| cfg_valid | input | 1 | Configuration write strobe |
| cfg_kind | input | 2 | 0 map, 1 enable, 2 owner, 3 none |
| cfg_port | input | 8 | Port addressed by the write |
| cfg_data | input | 12 | {sid, pid} / enable in bit 0 / owner in bits 2:0 |
| raise_valid | input | 1 | Peripheral raise strobe |
| raise_port | input | 8 | Port being raised |
| raise_bits | input | 8 | Status bits OR'ed into the port |
| init_stuck | input | 1 | Capture the stuck mask (idle only) |
| svc_start | input | 1 | Start one scan pass (idle only) |
| svc_show | input | 1 | Show-only pass when 1 |
| busy | output | 1 | A pass is in progress |
| svc_done | output | 1 | One-cycle end-of-pass pulse |
| evt_valid | output | 1 | Event available |
| evt_ready | input | 1 | Consumer accepts event |
| evt_port | output | 8 | Port index of the event |
| evt_sid | output | 4 | Slave id of the port |
| evt_pid | output | 8 | Peripheral id of the port |
| evt_bit | output | 3 | Status bit number |

## Verification
Directed cases cover the following:
- An empty map, which should yield a bare done pulse.
- A word-0 set mixing owned and foreign stuck ports, which separates the owner exemption from the mask itself.
- A port mapped above the interrupt limit, which is invisible until a lower map widens the range.
- A disabled port that is later enabled, which tells skip-and-keep from skip-and-drop.
- Back-to-back show passes followed by a normal pass, which tells non-clearing from clearing.

Random rounds then mix enables, raises across all eight words and show passes. They run against a stalling consumer, so that ordering across words, ports and bits is compared event by event while the held-event rule is checked under backpressure.

// File: rtl/irqd_pkg.sv
package irqd_pkg;
    localparam int SID_W = 4;
    localparam int PID_W = 8;
    localparam int ID_W  = SID_W + PID_W;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_FIND,
        ST_CHECK,
        ST_EMIT
    } irqd_state_e;

    typedef enum logic [1:0] {
        CFG_MAP    = 2'd0,
        CFG_ENABLE = 2'd1,
        CFG_OWNER  = 2'd2,
        CFG_NONE   = 2'd3
    } irqd_cfg_e;
endpackage

// File: rtl/irqd_lsb_pick.sv
module irqd_lsb_pick #(
    parameter int W = 32,
    localparam int IDX_W = (W > 1) ? $clog2(W) : 1
) (
    input  logic [W-1:0]     vec,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    // lowest set bit wins: scan downward so the last hit is the smallest
    always_comb begin
        idx = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec[i]) idx = IDX_W'(i);
        end
    end

    assign found = |vec;
endmodule

// File: rtl/irqd_range_track.sv
module irqd_range_track #(
    parameter int NUM_PORTS  = 256,
    parameter int WORD_W     = 32,
    parameter int INTR_LIMIT = 200,
    localparam int PORT_W = $clog2(NUM_PORTS),
    localparam int WBIT_W = $clog2(WORD_W),
    localparam int WIDX_W = PORT_W - WBIT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              map_accept,
    input  logic [PORT_W-1:0] map_port,
    output logic [WIDX_W-1:0] first_word,
    output logic [WIDX_W-1:0] last_word
);
    logic [PORT_W-1:0] lo_q, hi_q;
    logic              below_limit;

    assign below_limit = ({1'b0, map_port} < (PORT_W+1)'(INTR_LIMIT));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_q <= '1;
            hi_q <= '0;
        end else if (map_accept) begin
            if (map_port < lo_q) lo_q <= map_port;
            if (below_limit && (map_port > hi_q)) hi_q <= map_port;
        end
    end

    assign first_word = lo_q[PORT_W-1:WBIT_W];
    assign last_word  = hi_q[PORT_W-1:WBIT_W];

    AST_HI_LIMITED: assert property (@(posedge clk) disable iff (!rst_n)
        (map_accept && !below_limit) |=> $stable(hi_q)); // R3
    AST_LO_NEVER_UP: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_q <= $past(lo_q))); // R3
endmodule

// File: rtl/irqd_port_store.sv
module irqd_port_store import irqd_pkg::*; #(
    parameter int NUM_PORTS = 256,
    parameter int WORD_W    = 32,
    parameter int STAT_W    = 8,
    parameter int OWNER_W   = 3,
    localparam int PORT_W = $clog2(NUM_PORTS),
    localparam int WBIT_W = $clog2(WORD_W),
    localparam int WIDX_W = PORT_W - WBIT_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [OWNER_W-1:0] host_env,
    input  logic               cfg_valid,
    input  irqd_cfg_e          cfg_kind,
    input  logic [PORT_W-1:0]  cfg_port,
    input  logic [ID_W-1:0]    cfg_data,
    input  logic               raise_valid,
    input  logic [PORT_W-1:0]  raise_port,
    input  logic [STAT_W-1:0]  raise_bits,
    input  logic               clr_valid,
    input  logic [PORT_W-1:0]  clr_port,
    input  logic [STAT_W-1:0]  clr_bits,
    input  logic [PORT_W-1:0]  rd_port,
    input  logic [WIDX_W-1:0]  word_sel,
    output logic [STAT_W-1:0]  rd_stat,
    output logic               rd_en,
    output logic [SID_W-1:0]   rd_sid,
    output logic [PID_W-1:0]   rd_pid,
    output logic [WORD_W-1:0]  acc_word,
    output logic [WORD_W-1:0]  acc_word0,
    output logic [WORD_W-1:0]  own_word0,
    output logic               map_accept
);
    logic [NUM_PORTS-1:0][STAT_W-1:0]  stat_q;
    logic [NUM_PORTS-1:0]              en_q;
    logic [NUM_PORTS-1:0]              valid_q;
    logic [NUM_PORTS-1:0][OWNER_W-1:0] owner_q;
    logic [NUM_PORTS-1:0][ID_W-1:0]    id_q;
    logic                              same_port;

    assign map_accept = cfg_valid && (cfg_kind == CFG_MAP) && !valid_q[cfg_port];
    assign same_port  = raise_valid && clr_valid && (raise_port == clr_port);

    // pending status: clear removes only the bits that were read, a raise in
    // the same cycle survives
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_q <= '0;
        end else begin
            if (clr_valid)
                stat_q[clr_port] <= (stat_q[clr_port] & ~clr_bits)
                                  | (same_port ? raise_bits : '0);
            if (raise_valid && !same_port)
                stat_q[raise_port] <= stat_q[raise_port] | raise_bits;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q    <= '0;
            valid_q <= '0;
            owner_q <= '0;
            id_q    <= '0;
        end else if (cfg_valid) begin
            unique case (cfg_kind)
                CFG_MAP: begin
                    if (!valid_q[cfg_port]) begin
                        valid_q[cfg_port] <= 1'b1;
                        id_q[cfg_port]    <= cfg_data;
                    end
                end
                CFG_ENABLE: en_q[cfg_port]    <= cfg_data[0];
                CFG_OWNER:  owner_q[cfg_port] <= cfg_data[OWNER_W-1:0];
                CFG_NONE:   ;
            endcase
        end
    end

    assign rd_stat = stat_q[rd_port];
    assign rd_en   = en_q[rd_port];
    assign rd_sid  = id_q[rd_port][ID_W-1:PID_W];
    assign rd_pid  = id_q[rd_port][PID_W-1:0];

    for (genvar j = 0; j < WORD_W; j++) begin : g_acc
        assign acc_word[j]  = |stat_q[{word_sel, WBIT_W'(j)}];
        assign acc_word0[j] = |stat_q[j];
        assign own_word0[j] = (owner_q[j] == host_env);
    end

    AST_MAP_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_valid && (cfg_kind == CFG_MAP) && valid_q[cfg_port])
        |=> $stable(id_q)); // R2
endmodule

// File: rtl/irqd_scan_dispatch.sv
module irqd_scan_dispatch import irqd_pkg::*; #(
    parameter int NUM_PORTS  = 256,
    parameter int WORD_W     = 32,
    parameter int STAT_W     = 8,
    parameter int OWNER_W    = 3,
    parameter int INTR_LIMIT = 200,
    localparam int PORT_W = $clog2(NUM_PORTS),
    localparam int SBIT_W = $clog2(STAT_W)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [OWNER_W-1:0] host_env,
    input  logic               cfg_valid,
    input  logic [1:0]         cfg_kind,
    input  logic [PORT_W-1:0]  cfg_port,
    input  logic [11:0]        cfg_data,
    input  logic               raise_valid,
    input  logic [PORT_W-1:0]  raise_port,
    input  logic [STAT_W-1:0]  raise_bits,
    input  logic               init_stuck,
    input  logic               svc_start,
    input  logic               svc_show,
    output logic               busy,
    output logic               svc_done,
    output logic               evt_valid,
    input  logic               evt_ready,
    output logic [PORT_W-1:0]  evt_port,
    output logic [3:0]         evt_sid,
    output logic [7:0]         evt_pid,
    output logic [SBIT_W-1:0]  evt_bit
);
    localparam int WBIT_W = $clog2(WORD_W);
    localparam int WIDX_W = PORT_W - WBIT_W;

    irqd_state_e         state_q;
    logic [WIDX_W-1:0]   widx_q, last_q;
    logic [WORD_W-1:0]   wreg_q, stuck_q;
    logic [PORT_W-1:0]   cur_port_q;
    logic [STAT_W-1:0]   sreg_q;
    logic                show_q, done_q;

    logic [WIDX_W-1:0]   first_word, last_word;
    logic                map_accept;
    logic [STAT_W-1:0]   rd_stat;
    logic                rd_en;
    logic [SID_W-1:0]    rd_sid;
    logic [PID_W-1:0]    rd_pid;
    logic [WORD_W-1:0]   acc_word, acc_word0, own_word0;
    logic                w_found, s_found;
    logic [WBIT_W-1:0]   w_idx;
    logic [SBIT_W-1:0]   s_idx;
    logic                clr_valid;

    irqd_port_store #(
        .NUM_PORTS(NUM_PORTS), .WORD_W(WORD_W), .STAT_W(STAT_W), .OWNER_W(OWNER_W)
    ) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_env   (host_env),
        .cfg_valid  (cfg_valid),
        .cfg_kind   (irqd_cfg_e'(cfg_kind)),
        .cfg_port   (cfg_port),
        .cfg_data   (cfg_data),
        .raise_valid(raise_valid),
        .raise_port (raise_port),
        .raise_bits (raise_bits),
        .clr_valid  (clr_valid),
        .clr_port   (cur_port_q),
        .clr_bits   (rd_stat),
        .rd_port    (cur_port_q),
        .word_sel   (widx_q),
        .rd_stat    (rd_stat),
        .rd_en      (rd_en),
        .rd_sid     (rd_sid),
        .rd_pid     (rd_pid),
        .acc_word   (acc_word),
        .acc_word0  (acc_word0),
        .own_word0  (own_word0),
        .map_accept (map_accept)
    );

    irqd_range_track #(
        .NUM_PORTS(NUM_PORTS), .WORD_W(WORD_W), .INTR_LIMIT(INTR_LIMIT)
    ) u_range (
        .clk       (clk),
        .rst_n     (rst_n),
        .map_accept(map_accept),
        .map_port  (cfg_port),
        .first_word(first_word),
        .last_word (last_word)
    );

    irqd_lsb_pick #(.W(WORD_W)) u_pick_port (
        .vec(wreg_q), .found(w_found), .idx(w_idx)
    );

    irqd_lsb_pick #(.W(STAT_W)) u_pick_bit (
        .vec(sreg_q), .found(s_found), .idx(s_idx)
    );

    // state register and the datapath it steps
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            widx_q     <= '0;
            last_q     <= '0;
            wreg_q     <= '0;
            stuck_q    <= '0;
            cur_port_q <= '0;
            sreg_q     <= '0;
            show_q     <= 1'b0;
            done_q     <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (svc_start) begin
                        if (first_word <= last_word) begin
                            widx_q  <= first_word;
                            last_q  <= last_word;
                            show_q  <= svc_show;
                            state_q <= ST_LOAD;
                        end else begin
                            done_q <= 1'b1;
                        end
                    end else if (init_stuck) begin
                        stuck_q <= acc_word0 & ~own_word0;
                    end
                end
                ST_LOAD: begin
                    wreg_q  <= acc_word & ~((widx_q == '0) ? stuck_q : '0);
                    state_q <= ST_FIND;
                end
                ST_FIND: begin
                    if (!w_found) begin
                        if (widx_q == last_q) begin
                            done_q  <= 1'b1;
                            state_q <= ST_IDLE;
                        end else begin
                            widx_q  <= widx_q + 1'b1;
                            state_q <= ST_LOAD;
                        end
                    end else begin
                        cur_port_q     <= {widx_q, w_idx};
                        wreg_q[w_idx]  <= 1'b0;
                        state_q        <= ST_CHECK;
                    end
                end
                ST_CHECK: begin
                    if (rd_en) begin
                        sreg_q  <= rd_stat;
                        state_q <= ST_EMIT;
                    end else begin
                        state_q <= ST_FIND;
                    end
                end
                ST_EMIT: begin
                    if (!s_found)       state_q       <= ST_FIND;
                    else if (evt_ready) sreg_q[s_idx] <= 1'b0;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        busy      = (state_q != ST_IDLE);
        svc_done  = done_q;
        evt_valid = (state_q == ST_EMIT) && s_found;
        evt_port  = cur_port_q;
        evt_sid   = rd_sid;
        evt_pid   = rd_pid;
        evt_bit   = s_idx;
        clr_valid = (state_q == ST_CHECK) && rd_en && !show_q;
    end

    AST_EVT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && !evt_ready) |=> (evt_valid && $stable(evt_bit)
                                       && $stable(evt_port))); // R10
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        svc_done |-> !busy); // R10
    AST_SHOW_NO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        clr_valid |-> !show_q); // R7
    AST_SKIP_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CHECK && !rd_en) |=> (state_q == ST_FIND && !evt_valid)); // R5
    AST_STUCK_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && (evt_port[PORT_W-1:WBIT_W] == '0)) |-> !stuck_q[evt_port[WBIT_W-1:0]]); // R9
    AST_WORD_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (widx_q <= last_q)); // R3
endmodule

// File: tb/irqd_scan_dispatch_tb.sv
module irqd_scan_dispatch_tb;
    localparam int NP = 256;
    localparam int LIMIT = 200;
    localparam logic [2:0] HOST = 3'd1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [2:0] host_env = HOST;
    logic cfg_valid = 1'b0;
    logic [1:0] cfg_kind = 2'd0;
    logic [7:0] cfg_port = '0;
    logic [11:0] cfg_data = '0;
    logic raise_valid = 1'b0;
    logic [7:0] raise_port = '0;
    logic [7:0] raise_bits = '0;
    logic init_stuck = 1'b0;
    logic svc_start = 1'b0;
    logic svc_show = 1'b0;
    logic evt_ready = 1'b0;
    logic busy, svc_done, evt_valid;
    logic [7:0] evt_port;
    logic [3:0] evt_sid;
    logic [7:0] evt_pid;
    logic [2:0] evt_bit;

    always #5 clk = ~clk;

    irqd_scan_dispatch u_dut (
        .clk(clk), .rst_n(rst_n), .host_env(host_env),
        .cfg_valid(cfg_valid), .cfg_kind(cfg_kind), .cfg_port(cfg_port), .cfg_data(cfg_data),
        .raise_valid(raise_valid), .raise_port(raise_port), .raise_bits(raise_bits),
        .init_stuck(init_stuck), .svc_start(svc_start), .svc_show(svc_show),
        .busy(busy), .svc_done(svc_done), .evt_valid(evt_valid), .evt_ready(evt_ready),
        .evt_port(evt_port), .evt_sid(evt_sid), .evt_pid(evt_pid), .evt_bit(evt_bit)
    );

    // reference model
    logic [7:0]  stat_m [NP];
    logic        en_m   [NP];
    logic        val_m  [NP];
    logic [2:0]  own_m  [NP];
    logic [11:0] id_m   [NP];
    logic [31:0] stuck_m;
    int lo_m, hi_m;
    logic [22:0] exp_ev [4096];
    int n_exp;

    int checks = 0, errors = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wrap_up();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired (R10)");
        wrap_up();
    end

    function automatic void build_expected(input bit show);
        n_exp = 0;
        if ((lo_m >> 5) <= (hi_m >> 5)) begin
            for (int w = lo_m >> 5; w <= (hi_m >> 5); w++) begin
                for (int j = 0; j < 32; j++) begin
                    int p;
                    p = w * 32 + j;
                    if (stat_m[p] != 0 && !(w == 0 && stuck_m[j]) && en_m[p]) begin
                        for (int b = 0; b < 8; b++)
                            if (stat_m[p][b]) begin
                                exp_ev[n_exp] = {p[7:0], id_m[p], b[2:0]};
                                n_exp++;
                            end
                        if (!show) stat_m[p] = 8'h00;
                    end
                end
            end
        end
    endfunction

    task automatic cfg(input int kind, input int port, input int data);
        @(negedge clk);
        cfg_valid = 1'b1; cfg_kind = kind[1:0]; cfg_port = port[7:0]; cfg_data = data[11:0];
        @(negedge clk);
        cfg_valid = 1'b0;
        case (kind)
            0: if (!val_m[port]) begin
                   val_m[port] = 1'b1;
                   id_m[port] = data[11:0];
                   if (port < lo_m) lo_m = port;
                   if (port < LIMIT && port > hi_m) hi_m = port;
               end
            1: en_m[port] = data[0];
            2: own_m[port] = data[2:0];
            default: ;
        endcase
    endtask

    task automatic raise(input int port, input int bits);
        @(negedge clk);
        raise_valid = 1'b1; raise_port = port[7:0]; raise_bits = bits[7:0];
        @(negedge clk);
        raise_valid = 1'b0;
        stat_m[port] = stat_m[port] | bits[7:0];
    endtask

    task automatic do_init();
        for (int j = 0; j < 32; j++)
            stuck_m[j] = (stat_m[j] != 0) && (own_m[j] != HOST);
        @(negedge clk);
        init_stuck = 1'b1;
        @(negedge clk);
        init_stuck = 1'b0;
    endtask

    task automatic run_scan(input bit show, input string tag);
        int got;
        bit held;
        logic [22:0] held_ev;
        build_expected(show);
        got = 0;
        held = 0;
        held_ev = '0;
        @(negedge clk);
        svc_start = 1'b1; svc_show = show;
        @(negedge clk);
        svc_start = 1'b0;
        for (int guard = 0; guard < 20000; guard++) begin
            logic [22:0] cur;
            evt_ready = ($urandom % 4) != 0;
            #1;
            cur = {evt_port, evt_sid, evt_pid, evt_bit};
            if (held)
                chk(evt_valid && cur == held_ev, {tag, " R10 held event"}, {9'd0, cur}, {9'd0, held_ev});
            held = 0;
            if (svc_done) break;
            if (evt_valid && evt_ready) begin
                if (got < n_exp)
                    chk(cur == exp_ev[got], {tag, " R4 R8 event"}, {9'd0, cur}, {9'd0, exp_ev[got]});
                else
                    chk(1'b0, {tag, " R4 extra event"}, {9'd0, cur}, 32'd0);
                got++;
            end else if (evt_valid) begin
                held = 1;
                held_ev = cur;
            end
            @(negedge clk);
        end
        evt_ready = 1'b0;
        chk(got == n_exp, {tag, " event count"}, got, n_exp);
        chk(!busy, {tag, " R10 idle after done"}, {31'd0, busy}, 0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int p = 0; p < NP; p++) begin
            stat_m[p] = '0; en_m[p] = 0; val_m[p] = 0; own_m[p] = '0; id_m[p] = '0;
        end
        stuck_m = '0; lo_m = 255; hi_m = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy, "R1 busy at reset", {31'd0, busy}, 0);
        chk(!evt_valid, "R1 evt_valid at reset", {31'd0, evt_valid}, 0);
        chk(!svc_done, "R1 svc_done at reset", {31'd0, svc_done}, 0);

        // R1: nothing mapped, bare done
        raise(10, 8'h01);
        run_scan(0, "R1 empty range");

        // R9: stuck mask with owner exemption
        cfg(2, 3, HOST);
        cfg(2, 4, 2);
        raise(3, 8'h01);
        raise(4, 8'h02);
        raise(7, 8'h04);
        do_init();
        cfg(0, 3, 12'h103); cfg(1, 3, 1);
        cfg(0, 4, 12'h204); cfg(1, 4, 1);
        cfg(0, 7, 12'h307); cfg(1, 7, 1);
        cfg(1, 10, 1);
        run_scan(0, "R9 stuck mask");

        // R2: second map ignored, kind 3 no effect
        cfg(0, 5, 12'h1AB);
        cfg(0, 5, 12'h2CD);
        cfg(3, 5, 12'hFFF);
        cfg(1, 5, 1);
        raise(5, 8'h81);
        run_scan(0, "R2 map once");

        // R3: port above the limit does not widen the range
        cfg(0, 220, 12'h4DC); cfg(1, 220, 1);
        raise(220, 8'h40);
        run_scan(0, "R3 out of range");
        cfg(0, 199, 12'h5C7); cfg(1, 199, 1);
        run_scan(0, "R3 widened range");

        // R5: disabled port kept pending
        cfg(1, 5, 0);
        raise(5, 8'h3C);
        run_scan(0, "R5 disabled skipped");
        cfg(1, 5, 1);
        run_scan(0, "R5 enabled later");

        // R7 then R6
        raise(5, 8'hA5);
        raise(199, 8'h11);
        run_scan(1, "R7 show pass 1");
        run_scan(1, "R7 show pass 2");
        run_scan(0, "R6 clearing pass");
        run_scan(0, "R6 nothing left");

        // random rounds
        for (int p = 0; p < NP; p++)
            cfg(0, p, {p[3:0], ~p[7:0]});
        for (int round = 0; round < 25; round++) begin
            for (int k = 0; k < 16; k++)
                cfg(1, $urandom % NP, $urandom % 4 != 0);
            for (int k = 0; k < 10; k++)
                raise($urandom % NP, $urandom % 256);
            run_scan(($urandom % 4) == 0, "R4 R8 random round");
        end
        wrap_up();
    end
endmodule